// File: doc/BRIEF.md
# Host-port RAM access controller

This block gives an external host access to an on-chip data RAM through a narrow register port. The host selects one of the block's internal registers with a 6-bit index while holding the active-low select line low, then reads or writes it. Three registers are reachable: an address register holding a RAM word index, a data register holding one RAM word, and a memory control register that issues commands.

The control register supports two styles of access. In the one-shot style the host sets a read or a write command bit. The block moves a single word between the data register and the RAM at the current address, then clears the command bit itself. In the locked style the host sets the lock bit together with one direction bit. After that, every access to the data register streams a word to or from the RAM and advances the address, so a buffer moves with one register access per word. The direction latched with the lock cannot be swapped while the lock stays set. It can only be dropped.

Top module: `hostram_port`

## Requirements
- R1: After reset the control, address and data registers all read as 0.
- R2: Register numbers are control = 0, address = 1, data = 2. A register is reached only while `host_sel_n` is 0 and `host_idx` matches its number. Accesses with `host_sel_n` at 1 change nothing, and `host_rdata` is 0 whenever no register is read, including unused indices.
- R3: The control register reads as {24'b0, lock, 1'b0, write, 5'b0}: the lock at bit 7 and the write bit at bit 5. Every other bit reads 0, including the read command at bit 6.
- R4: Writing the control register with bit 5 = 1 and bit 7 = 0 stores the data register into the RAM word at the address register once. Bit 5 then clears itself on the following cycle, and the address does not change.
- R5: Writing the control register with bit 6 = 1 and bit 7 = 0 loads the RAM word at the address into the data register once. The read command clears itself, and the address does not change.
- R6: Writing the control register with bits 7 and 5 set enters streaming write. Each data-register write then stores that word at the address and advances the address by one.
- R7: Writing the control register with bits 7 and 6 set from the unlocked state enters streaming read and prefetches the word at the address into the data register. Each data-register read then returns the current word, advances the address by one and prefetches the next word.
- R8: While the lock is set, a control write that keeps bit 7 set cannot set a direction bit that is not already held. A held direction bit that is written 0 is cleared, which ends the streaming mode.
- R9: Writing the control register with bit 7 = 0 leaves streaming mode. Later data-register accesses neither touch the RAM nor move the address.
- R10: A control write with bits 6 and 5 both set is illegal and is ignored entirely: the control register is unchanged and the RAM is not touched.
- R11: The address counts modulo the RAM depth, so after the last word it continues at word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel_n | input | 1 | Active-low register-port select |
| host_idx | input | IW (6) | Register number |
| host_wr | input | 1 | Register write strobe, one cycle per write |
| host_rd | input | 1 | Register read strobe, one cycle per read |
| host_wdata | input | DW (32) | Register write data |
| host_rdata | output | DW (32) | Register read data, combinational |

## Verification
Every cycle, the assertions check four things. The read and write directions never coexist in the control register. One-shot commands clear themselves after one cycle. A streaming data access moves the address by exactly one word, and the address never moves while the port is deselected or unlocked. The bench has to show the data path itself. That covers which words actually land in the RAM, what the prefetch returns across the address wrap, and that illegal or locked-out control writes leave the RAM untouched. These can only be seen by sweeping addresses and reading the words back against the bench's own memory model.

// File: rtl/hostram_port.sv
module hostram_port #(
  parameter int DW       = 32,
  parameter int DEPTH    = 16,
  parameter int IW       = 6,
  parameter int CTRL_IDX = 0,
  parameter int ADDR_IDX = 1,
  parameter int DATA_IDX = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_sel_n,
  input  logic [IW-1:0] host_idx,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic          lock_q, rd_q, wr_q;
  logic          lock_d, rd_d, wr_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  wire sel_ctrl = !host_sel_n && host_idx == IW'(CTRL_IDX);
  wire sel_addr = !host_sel_n && host_idx == IW'(ADDR_IDX);
  wire sel_data = !host_sel_n && host_idx == IW'(DATA_IDX);

  wire ctrl_we = sel_ctrl && host_wr;
  wire addr_we = sel_addr && host_wr;
  wire data_we = sel_data && host_wr;
  wire data_re = sel_data && host_rd;

  wire cmd_lock = host_wdata[7];
  wire cmd_rd   = host_wdata[6];
  wire cmd_wr   = host_wdata[5];
  wire cmd_ok   = ctrl_we && !(cmd_rd && cmd_wr);

  wire one_wr   = wr_q && !lock_q;
  wire one_rd   = rd_q && !lock_q;
  wire strm_wr  = wr_q && lock_q;
  wire strm_rd  = rd_q && lock_q;
  wire enter_rd = cmd_ok && cmd_lock && cmd_rd && !lock_q;

  wire [AW-1:0] addr_inc = addr_q + 1'b1;
  wire          step     = (strm_wr && data_we) || (strm_rd && data_re);
  wire          mem_we   = one_wr || (strm_wr && data_we);
  wire [DW-1:0] mem_wd   = one_wr ? data_q : host_wdata;

  always_comb begin
    lock_d = lock_q;
    rd_d   = rd_q && !one_rd;
    wr_d   = wr_q && !one_wr;
    if (cmd_ok) begin
      lock_d = cmd_lock;
      if (lock_q && cmd_lock) begin
        rd_d = rd_q && cmd_rd;
        wr_d = wr_q && cmd_wr;
      end else begin
        rd_d = cmd_rd;
        wr_d = cmd_wr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      lock_q <= lock_d;
      rd_q   <= rd_d;
      wr_q   <= wr_d;
      if (addr_we)   addr_q <= host_wdata[AW-1:0];
      else if (step) addr_q <= addr_inc;
      if (data_we)                 data_q <= host_wdata;
      else if (one_rd || enter_rd) data_q <= mem[addr_q];
      else if (strm_rd && data_re) data_q <= mem[addr_inc];
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[addr_q] <= mem_wd;
  end

  always_comb begin
    host_rdata = '0;
    if (host_rd) begin
      if (sel_ctrl)      host_rdata = DW'({lock_q, 1'b0, wr_q, 5'b0});
      else if (sel_addr) host_rdata = DW'(addr_q);
      else if (sel_data) host_rdata = data_q;
    end
  end
endmodule

// File: rtl/hostram_port_chk.sv
module hostram_port_chk #(
  parameter int IW       = 6,
  parameter int AW       = 4,
  parameter int CTRL_IDX = 0,
  parameter int ADDR_IDX = 1,
  parameter int DATA_IDX = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_sel_n,
  input logic [IW-1:0] host_idx,
  input logic          host_wr,
  input logic          host_rd,
  input logic          lock_q,
  input logic          rd_q,
  input logic          wr_q,
  input logic [AW-1:0] addr_q
);
  wire c_we = !host_sel_n && host_wr && host_idx == IW'(CTRL_IDX);
  wire a_we = !host_sel_n && host_wr && host_idx == IW'(ADDR_IDX);
  wire d_we = !host_sel_n && host_wr && host_idx == IW'(DATA_IDX);
  wire d_re = !host_sel_n && host_rd && host_idx == IW'(DATA_IDX);

  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_q && wr_q)); // R10
  AST_SINGLE_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && !lock_q && !c_we) |=> !wr_q); // R4
  AST_SINGLE_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q && !lock_q && !c_we) |=> !rd_q); // R5
  AST_STREAM_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && wr_q && d_we && !a_we) |=> addr_q == AW'($past(addr_q) + 1'b1)); // R6
  AST_STREAM_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && rd_q && d_re && !a_we) |=> addr_q == AW'($past(addr_q) + 1'b1)); // R7
  AST_UNLOCKED_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && !a_we) |=> $stable(addr_q)); // R9
  AST_DESELECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel_n |=> $stable(addr_q) && $stable(lock_q)); // R2
endmodule

bind hostram_port hostram_port_chk #(
  .IW(IW), .AW(AW), .CTRL_IDX(CTRL_IDX), .ADDR_IDX(ADDR_IDX), .DATA_IDX(DATA_IDX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_sel_n(host_sel_n), .host_idx(host_idx),
  .host_wr(host_wr), .host_rd(host_rd), .lock_q(lock_q), .rd_q(rd_q),
  .wr_q(wr_q), .addr_q(addr_q)
);

// File: tb/hostram_port_tb_top.sv
module hostram_port_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        host_sel_n = 1;
  logic [5:0]  host_idx = '0;
  logic        host_wr = 0, host_rd = 0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  int total = 0, bad = 0;
  logic [31:0] model [16];
  logic [31:0] v;

  hostram_port dut_i (.*);

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [31:0] val);
    @(negedge clk);
    host_sel_n = 0; host_wr = 1; host_idx = 6'(idx); host_wdata = val;
    @(negedge clk);
    host_sel_n = 1; host_wr = 0;
  endtask

  task automatic rd(int idx, output logic [31:0] val);
    @(negedge clk);
    host_sel_n = 0; host_rd = 1; host_idx = 6'(idx);
    #2 val = host_rdata;
    @(negedge clk);
    host_sel_n = 1; host_rd = 0;
  endtask

  function automatic logic [31:0] pat(int a, int s);
    return 32'hC0DE0000 + 32'(a * 7 + s * 256 + 3);
  endfunction

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 addr", v, 0);
    rd(2, v); chk("R1 data", v, 0);

    @(negedge clk);
    host_sel_n = 1; host_wr = 1; host_idx = 6'd1; host_wdata = 32'd9;
    @(negedge clk);
    host_wr = 0; host_rd = 1;
    #2 chk("R2 deselected rdata", host_rdata, 0);
    @(negedge clk) host_rd = 0;
    rd(1, v); chk("R2 deselected write ignored", v, 0);
    wr(7, 32'hFFFF_FFFF);
    rd(7, v); chk("R2 unused index", v, 0);
    rd(1, v); chk("R2 addr after unused write", v, 0);

    wr(0, 32'hFFFF_FF9F);
    rd(0, v); chk("R3 ctrl readback mask", v, 32'h80);
    wr(0, 0);
    rd(0, v); chk("R3 ctrl cleared", v, 0);

    for (int a = 0; a < 16; a++) begin
      wr(1, 32'(a)); wr(2, pat(a, 1)); wr(0, 32'h20);
      model[a] = pat(a, 1);
      rd(0, v); chk("R4 write bit self-clears", v, 0);
    end
    for (int a = 0; a < 16; a++) begin
      wr(2, 0); wr(1, 32'(a)); wr(0, 32'h40);
      rd(2, v); chk("R5 single read", v, model[a]);
      rd(1, v); chk("R5 address unchanged", v, 32'(a));
    end

    wr(1, 14); wr(0, 32'hA0);
    rd(0, v); chk("R6 ctrl in stream write", v, 32'hA0);
    for (int k = 0; k < 6; k++) begin
      wr(2, pat(k, 2));
      model[(14 + k) % 16] = pat(k, 2);
    end
    rd(1, v); chk("R11 address wrapped", v, 4);
    wr(0, 0);
    wr(2, 32'hDEAD_BEEF);
    rd(1, v); chk("R9 no step after unlock", v, 4);

    wr(1, 13); wr(0, 32'hC0);
    rd(0, v); chk("R7 ctrl hides read bit", v, 32'h80);
    for (int k = 0; k < 5; k++) begin
      rd(2, v); chk("R7 stream read word", v, model[(13 + k) % 16]);
    end
    rd(1, v); chk("R7 R11 address after stream read", v, 2);
    wr(0, 0);
    rd(2, v); rd(1, v); chk("R9 read no step after unlock", v, 2);

    wr(1, 8); wr(0, 32'hA0);
    wr(0, 32'hC0);
    rd(0, v); chk("R8 locked write cannot add read", v, 32'h80);
    wr(2, 32'h0000_0055);
    rd(1, v); chk("R8 mode ended no step", v, 8);
    wr(0, 32'hA0);
    rd(0, v); chk("R8 direction not set while locked", v, 32'h80);
    wr(0, 0);

    wr(1, 3); wr(2, 32'h77); wr(0, 32'h60);
    rd(0, v); chk("R10 illegal ignored unlocked", v, 0);
    wr(0, 32'hA0); wr(0, 32'hE0);
    rd(0, v); chk("R10 illegal ignored locked", v, 32'hA0);
    wr(0, 0);

    for (int a = 0; a < 16; a++) begin
      wr(1, 32'(a)); wr(0, 32'h40);
      rd(2, v); chk("R4 R8 R10 final RAM contents", v, model[a]);
    end

    finish_run();
  end
endmodule